// File: doc/BRIEF.md
# Branch Sample Capture Buffer

This block keeps a short record of retired taken branches. Once software sets the enable bit in its configuration word, each retire strobe stores the branch source and target addresses in the slot named by the next-write index, and the index moves on by one. The buffer fills once from the index it was started at. When the last slot is written it clears its own enable, wraps the index to zero and ignores all later branches until software enables it again.

While capture is enabled, a counter-overflow event is held back so that the buffer can fill around it. The held event is released as a single interrupt pulse when capture stops, either because the buffer saturates or because software clears the enable. Software reaches the configuration/status word and every source and target register through one register port. It can plant marker values in any entry register, and by writing the configuration word it can restart, rewind or reset the capture.

Top module: `brsamp_buf`

## Requirements
- R1: After reset the configuration word reads 0x18, every entry register reads zero and irq_out is low.
- R2: Register address 2*i selects the source of entry i and 2*i+1 selects its target (i = 0..15). Address 32 selects the configuration word. Addresses 33..63 read zero and writes to them are ignored.
- R3: The configuration word holds enable at bit 2, valid flag at bit 5, next-write index at bits 19:16 and a 3-bit counter-select field at bits 26:24. All four are writable and read back live state. Bits 4:3 always read 11b whatever was written, and all other bits read zero.
- R4: When enable is set and br_valid is high at a clock edge, br_src and br_dst are stored in the entry at the next-write index, the index increments and the valid flag becomes 1.
- R5: A capture into entry 15 clears enable and wraps the index to 0. Later strobes change no entry and no configuration field.
- R6: While enable is clear, strobes on br_valid change no entry, the index or the valid flag.
- R7: A configuration write loads the index, valid and enable fields as written. Capture continues from the written index, and writing zero clears the index and the valid flag.
- R8: An overflow on ovf_in while enable is set (and stays set through that edge) is held, and irq_out stays low.
- R9: A held overflow is delivered as one irq_out pulse of one cycle, in the cycle after enable clears, whether by saturation or by a software write. Several held overflows give a single pulse. An overflow while enable is clear pulses irq_out in the next cycle.
- R10: A configuration write in the same cycle as a retire strobe drops that branch: no entry changes and the index takes the written value.
- R11: A software write stores the full 64-bit value in the addressed entry register. If a capture writes the same entry in that cycle, the software value wins for the addressed register and the other register of the pair takes the captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| br_valid | input | 1 | Retired taken branch strobe |
| br_src | input | 64 | Branch source address |
| br_dst | input | 64 | Branch target address |
| ovf_in | input | 1 | Counter-overflow event |
| irq_out | output | 1 | Interrupt pulse (one cycle) |
| rg_wr | input | 1 | Register write strobe |
| rg_addr | input | 6 | Register address |
| rg_wdata | input | 64 | Register write data |
| rg_rdata | output | 64 | Register read data (combinational) |

## Verification
Directed sequences run the fill from index 0 to saturation with overflows scattered through it. They also start a fill at index 14, send strobes while disabled, and stop a fill by a software clear. Between them, these separate a release caused by saturation from one caused by a software write, and a dropped strobe from a stored one. A configuration write in the same cycle as a strobe, and a software target write that collides with a capture on the same entry, check which side wins each register. A seeded random phase then mixes strobes, overflows, rewinds and entry writes at random rates. This reaches index and priority combinations that the directed cases do not set up.

// File: rtl/brsamp_pkg.sv
package brsamp_pkg;
    localparam int CFG_EN_BIT  = 2;
    localparam int CFG_FIX_LSB = 3;
    localparam int CFG_VB_BIT  = 5;
    localparam int CFG_IDX_LSB = 16;
    localparam int CFG_SEL_LSB = 24;
    localparam int SEL_W       = 3;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SRC  = 2'd1,
        ACC_DST  = 2'd2,
        ACC_CFG  = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/brsamp_decode.sv
module brsamp_decode
    import brsamp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int RA_W  = IDX_W + 2
) (
    input  logic [RA_W-1:0]  addr,
    output acc_kind_e        kind,
    output logic [IDX_W-1:0] entry
);
    always_comb begin
        entry = addr[IDX_W:1];
        if (!addr[RA_W-1]) begin
            kind = addr[0] ? ACC_DST : ACC_SRC;
        end else if (addr[RA_W-2:0] == '0) begin
            kind = ACC_CFG;
        end else begin
            kind = ACC_NONE;
        end
    end
endmodule

// File: rtl/brsamp_ctrl.sv
module brsamp_ctrl
    import brsamp_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic              ovf_in,
    input  logic              cfg_wr,
    input  logic              wd_en,
    input  logic              wd_vb,
    input  logic [IDX_W-1:0]  wd_idx,
    input  logic [SEL_W-1:0]  wd_sel,
    output logic              cap_we,
    output logic [IDX_W-1:0]  cap_idx,
    output logic [WORD_W-1:0] cfg_word,
    output logic              irq_out
);
    typedef struct packed {
        logic             en;
        logic             vb;
        logic [IDX_W-1:0] idx;
        logic [SEL_W-1:0] sel;
        logic             pend;
        logic             irq;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     hold;

    always_comb begin
        st_d   = st_q;
        cap_we = st_q.en && br_valid && !cfg_wr;
        if (cfg_wr) begin
            st_d.en  = wd_en;
            st_d.vb  = wd_vb;
            st_d.idx = wd_idx;
            st_d.sel = wd_sel;
        end else if (cap_we) begin
            st_d.idx = IDX_W'(st_q.idx + 1'b1);
            st_d.vb  = 1'b1;
            if (st_q.idx == LAST) begin
                st_d.en = 1'b0;
            end
        end
        hold      = ovf_in || st_q.pend;
        st_d.pend = hold && st_d.en;
        st_d.irq  = hold && !st_d.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_idx = st_q.idx;
    assign irq_out = st_q.irq;

    always_comb begin
        cfg_word                              = '0;
        cfg_word[CFG_EN_BIT]                  = st_q.en;
        cfg_word[CFG_FIX_LSB +: 2]            = 2'b11;
        cfg_word[CFG_VB_BIT]                  = st_q.vb;
        cfg_word[CFG_IDX_LSB +: IDX_W]        = st_q.idx;
        cfg_word[CFG_SEL_LSB +: SEL_W]        = st_q.sel;
    end

    // R4: a capture advances the index and marks the buffer valid
    p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && br_valid && !cfg_wr) |=>
            (st_q.idx == IDX_W'($past(st_q.idx) + 1'b1)) && st_q.vb);

    // R5: a capture into the last slot stops capture and wraps the index
    p_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && br_valid && !cfg_wr && st_q.idx == LAST) |=>
            (!st_q.en && st_q.idx == '0));

    // R6: while disabled and not written, the index and enable stay put
    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !cfg_wr) |=> ($stable(st_q.idx) && !st_q.en));

    // R8: an overflow during a continuing capture is held, not delivered
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_in && st_q.en && !cfg_wr && !(br_valid && st_q.idx == LAST)) |=>
            (!irq_out && st_q.pend));

    // R9: a held overflow is released when enable drops
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.en) && $past(st_q.pend)) |-> irq_out);

    // R9: the interrupt is a single-cycle pulse
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ovf_in) |=> !irq_out);
endmodule

// File: rtl/brsamp_store.sv
module brsamp_store
    import brsamp_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_we,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [WORD_W-1:0] cap_src,
    input  logic [WORD_W-1:0] cap_dst,
    input  logic              sw_we,
    input  logic              sw_dst,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [WORD_W-1:0] sw_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_src,
    output logic [WORD_W-1:0] rd_dst
);
    logic [WORD_W-1:0] src_d [DEPTH];
    logic [WORD_W-1:0] src_q [DEPTH];
    logic [WORD_W-1:0] dst_d [DEPTH];
    logic [WORD_W-1:0] dst_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic hit_cap, hit_sw;

        always_comb begin
            hit_cap  = cap_we && (cap_idx == IDX_W'(e));
            hit_sw   = sw_we && (sw_idx == IDX_W'(e));
            src_d[e] = src_q[e];
            dst_d[e] = dst_q[e];
            if (hit_cap) begin
                src_d[e] = cap_src;
                dst_d[e] = cap_dst;
            end
            if (hit_sw) begin
                if (sw_dst) begin
                    dst_d[e] = sw_data;
                end else begin
                    src_d[e] = sw_data;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_q[e] <= '0;
                dst_q[e] <= '0;
            end else begin
                src_q[e] <= src_d[e];
                dst_q[e] <= dst_d[e];
            end
        end

        // R11: software write wins over a capture into the same register
        p_swwins_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_cap && hit_sw && sw_dst) |=>
                (dst_q[e] == $past(sw_data)) && (src_q[e] == $past(cap_src)));
    end

    assign rd_src = src_q[rd_idx];
    assign rd_dst = dst_q[rd_idx];
endmodule

// File: rtl/brsamp_buf.sv
module brsamp_buf
    import brsamp_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int RA_W  = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [WORD_W-1:0] br_src,
    input  logic [WORD_W-1:0] br_dst,
    input  logic              ovf_in,
    output logic              irq_out,
    input  logic              rg_wr,
    input  logic [RA_W-1:0]   rg_addr,
    input  logic [WORD_W-1:0] rg_wdata,
    output logic [WORD_W-1:0] rg_rdata
);
    acc_kind_e         kind;
    logic [IDX_W-1:0]  entry;
    logic              cfg_wr, ent_wr;
    logic              cap_we;
    logic [IDX_W-1:0]  cap_idx;
    logic [WORD_W-1:0] cfg_word, rd_src, rd_dst;

    brsamp_decode #(.DEPTH(DEPTH)) u_dec (
        .addr  (rg_addr),
        .kind  (kind),
        .entry (entry)
    );

    assign cfg_wr = rg_wr && (kind == ACC_CFG);
    assign ent_wr = rg_wr && ((kind == ACC_SRC) || (kind == ACC_DST));

    brsamp_ctrl #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .br_valid (br_valid),
        .ovf_in   (ovf_in),
        .cfg_wr   (cfg_wr),
        .wd_en    (rg_wdata[CFG_EN_BIT]),
        .wd_vb    (rg_wdata[CFG_VB_BIT]),
        .wd_idx   (rg_wdata[CFG_IDX_LSB +: IDX_W]),
        .wd_sel   (rg_wdata[CFG_SEL_LSB +: SEL_W]),
        .cap_we   (cap_we),
        .cap_idx  (cap_idx),
        .cfg_word (cfg_word),
        .irq_out  (irq_out)
    );

    brsamp_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_we  (cap_we),
        .cap_idx (cap_idx),
        .cap_src (br_src),
        .cap_dst (br_dst),
        .sw_we   (ent_wr),
        .sw_dst  (kind == ACC_DST),
        .sw_idx  (entry),
        .sw_data (rg_wdata),
        .rd_idx  (entry),
        .rd_src  (rd_src),
        .rd_dst  (rd_dst)
    );

    always_comb begin
        unique case (kind)
            ACC_SRC: rg_rdata = rd_src;
            ACC_DST: rg_rdata = rd_dst;
            ACC_CFG: rg_rdata = cfg_word;
            default: rg_rdata = '0;
        endcase
    end

    // R3: the fixed field always reads as 11b on a config read
    p_fixbits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_CFG) |-> (rg_rdata[CFG_FIX_LSB +: 2] == 2'b11));
endmodule

// File: tb/brsamp_buf_tb.sv
module brsamp_buf_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [63:0] br_src = '0, br_dst = '0;
    logic        ovf_in = 1'b0;
    logic        irq_out;
    logic        rg_wr = 1'b0;
    logic [5:0]  rg_addr = '0;
    logic [63:0] rg_wdata = '0;
    logic [63:0] rg_rdata;

    int checks = 0;
    int errors = 0;

    logic [63:0] ms [16];
    logic [63:0] md [16];
    logic        m_en, m_vb, m_pend, m_irq;
    logic [3:0]  m_idx;
    logic [2:0]  m_sel;

    always #10 clk = ~clk;

    brsamp_buf u_dut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_src(br_src),
        .br_dst(br_dst), .ovf_in(ovf_in), .irq_out(irq_out), .rg_wr(rg_wr),
        .rg_addr(rg_addr), .rg_wdata(rg_wdata), .rg_rdata(rg_rdata)
    );

    function automatic logic [63:0] cfg_exp();
        return 64'h18 | (64'(m_en) << 2) | (64'(m_vb) << 5)
             | (64'(m_idx) << 16) | (64'(m_sel) << 24);
    endfunction

    function automatic logic [63:0] model_read(input logic [5:0] a);
        if (a == 6'd32) return cfg_exp();
        if (a < 6'd32) return a[0] ? md[a[4:1]] : ms[a[4:1]];
        return '0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin ms[i] = '0; md[i] = '0; end
        m_en = 0; m_vb = 0; m_idx = 0; m_sel = 0; m_pend = 0; m_irq = 0;
    endtask

    task automatic model_step(input logic bv, input logic [63:0] s, input logic [63:0] d,
                              input logic ov, input logic wr, input logic [5:0] a,
                              input logic [63:0] wd);
        logic cfgw, cap, hold;
        cfgw = wr && (a == 6'd32);
        cap  = m_en && bv && !cfgw;
        if (cap) begin ms[m_idx] = s; md[m_idx] = d; end
        if (wr && a < 6'd32) begin
            if (a[0]) md[a[4:1]] = wd; else ms[a[4:1]] = wd;
        end
        if (cfgw) begin
            m_en = wd[2]; m_vb = wd[5]; m_idx = wd[19:16]; m_sel = wd[26:24];
        end else if (cap) begin
            if (m_idx == 4'd15) m_en = 0;
            m_idx = m_idx + 4'd1;
            m_vb  = 1;
        end
        hold   = ov || m_pend;
        m_pend = hold && m_en;
        m_irq  = hold && !m_en;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, update model at edge, check irq at next negedge
    task automatic cyc(input logic bv, input logic [63:0] s, input logic [63:0] d,
                       input logic ov, input logic wr, input logic [5:0] a,
                       input logic [63:0] wd);
        br_valid = bv; br_src = s; br_dst = d; ovf_in = ov;
        rg_wr = wr; rg_addr = a; rg_wdata = wd;
        @(posedge clk);
        model_step(bv, s, d, ov, wr, a, wd);
        @(negedge clk);
        br_valid = 0; ovf_in = 0; rg_wr = 0;
        check("R8 R9 irq_out", 64'(irq_out), 64'(m_irq));
    endtask

    task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask
    task automatic br(input logic ov = 0);
        cyc(1, {$urandom, $urandom}, {$urandom, $urandom}, ov, 0, 0, 0);
    endtask
    task automatic wcfg(input logic [63:0] wd); cyc(0, 0, 0, 0, 1, 6'd32, wd); endtask

    task automatic rd(input string tag, input logic [5:0] a);
        rg_wr = 0; rg_addr = a;
        #1;
        check(tag, rg_rdata, model_read(a));
    endtask

    task automatic rd_lit(input string tag, input logic [5:0] a, input logic [63:0] exp);
        rg_wr = 0; rg_addr = a;
        #1;
        check(tag, rg_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] keep;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check("R1 irq_out", 64'(irq_out), 0);
        rd_lit("R1 cfg", 6'd32, 64'h18);
        rd_lit("R1 src0", 6'd0, 0);
        rd_lit("R1 dst15", 6'd31, 0);
        rd_lit("R2 unmapped", 6'd45, 0);

        // R3: forced bits and unused bits
        wcfg(64'hF000_0000_0000_0000);
        rd_lit("R3 cfg junk", 6'd32, 64'h18);
        wcfg(64'h0000_0000_0500_0004);
        rd_lit("R3 cfg en sel", 6'd32, 64'h0500_001C);
        cyc(0, 0, 0, 0, 1, 6'd50, 64'hDEAD);   // R2: ignored write
        rd_lit("R2 ignored", 6'd50, 0);

        // R4: captures with gaps
        br(); idle(); br(); br(); idle();
        rd("R4 cfg after 3", 6'd32);
        for (int a = 0; a < 6; a++) rd("R4 R2 entries", 6'(a));

        // R8 then R5/R9 saturation release
        br(1);
        for (int i = 0; i < 11; i++) br(i == 5);
        br();                                   // 16th capture
        rd_lit("R5 cfg full", 6'd32, 64'h0500_0038);
        keep = ms[0];
        br(); br();
        rd_lit("R5 src0 kept", 6'd0, keep);
        rd("R5 cfg", 6'd32);

        // R6 disabled strobes
        br(); br();
        rd("R6 cfg", 6'd32);
        rd("R6 dst0", 6'd1);
        // R9 overflow while disabled
        cyc(0, 0, 0, 1, 0, 0, 0);
        check("R9 direct pulse", 64'(irq_out), 1);
        idle();

        // R11 marker writes
        cyc(0, 0, 0, 0, 1, 6'd11, 64'hFFFF_FFFF_FFFF_FFFE);
        cyc(0, 0, 0, 0, 1, 6'd6, 64'h1234_5678_9ABC_DEF0);
        rd_lit("R11 marker", 6'd11, 64'hFFFF_FFFF_FFFF_FFFE);
        rd("R11 src3", 6'd6);

        // R7 reset and start at 14
        wcfg(0);
        rd_lit("R7 cfg zero", 6'd32, 64'h18);
        wcfg(64'h000E_0004);
        br(); br();
        rd("R7 e14", 6'd28);
        rd("R7 e15", 6'd31);
        rd_lit("R7 R5 cfg", 6'd32, 64'h38);

        // R9 software clear releases, repeated overflow collapses
        wcfg(64'h0000_0004);
        br(); br(1); cyc(0, 0, 0, 1, 0, 0, 0);
        check("R8 held", 64'(irq_out), 0);
        wcfg(64'h0002_0020);
        check("R9 sw release", 64'(irq_out), 1);
        idle();
        check("R9 single pulse", 64'(irq_out), 0);

        // R10 config write with a strobe
        keep = ms[4];
        cyc(1, 64'hAAAA, 64'hBBBB, 0, 1, 6'd32, 64'h0004_0024);
        rd_lit("R10 src4 kept", 6'd8, keep);
        rd("R10 cfg", 6'd32);
        // R11 collision on entry 4 target
        cyc(1, 64'h1111, 64'h2222, 0, 1, 6'd9, 64'h3333);
        rd_lit("R11 dst sw wins", 6'd9, 64'h3333);
        rd_lit("R11 src captured", 6'd8, 64'h1111);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [63:0] wd;
            r = $urandom_range(0, 99);
            wd = {$urandom, $urandom};
            if (r < 3) begin
                wd[2] = ($urandom_range(0, 3) != 0);
                cyc($urandom_range(0, 1), {$urandom, $urandom}, {$urandom, $urandom},
                    ($urandom_range(0, 19) == 0), 1, 6'd32, wd);
            end else if (r < 6) begin
                cyc($urandom_range(0, 1), {$urandom, $urandom}, {$urandom, $urandom},
                    ($urandom_range(0, 19) == 0), 1, 6'($urandom_range(0, 63)), wd);
            end else begin
                cyc($urandom_range(0, 1), {$urandom, $urandom}, {$urandom, $urandom},
                    ($urandom_range(0, 19) == 0), 0, 0, 0);
            end
            rd("R4 R5 R7 R11 random read", 6'($urandom_range(0, 63)));
            rd("R3 random cfg", 6'd32);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule